// File: doc/BRIEF.md
# Serial Slot Transmitter with Zero Insertion

This block feeds a low-rate serial channel that rides inside reserved bit positions of a framed line. A host writes 8-bit bytes into a holding register. A framer pulses a one-cycle request strobe at each reserved position, and the block answers each strobe with one outgoing bit. Data bits leave least significant bit first.

After the last bit of a byte has gone out, a status flag tells the host that the holding register may be refilled. An active-low interrupt follows this flag when the interrupt enable is set. If the host misses the update, the block sends the previous byte again. When zero insertion is on, the block adds a 0 after every five transmitted 1s in a row. The line then never carries six 1s in a row, so neither a flag byte (01111110) nor an abort (11111111) can appear inside the data. The inserted 0 uses a strobe of its own, and the data bit it displaces goes out on the next strobe.

Top module: `serial_slot_tx`

## Requirements
- R1: After reset, `tx_bit` is 0 and `empty` is 1. The holding register resets to 0x00, so a byte sent before any host write is all zeros.
- R2: Each strobe on `bit_req` moves exactly one bit to `tx_bit`. The new bit shows on the cycle after the strobe and stays until the next strobe. A byte's data bits leave in the order bit 0 first, bit 7 last.
- R3: `empty` becomes 1 on the cycle after the strobe that sends bit 7 of a byte.
- R4: `irq_n` is 0 exactly while `empty` is 1 and `irq_en` is 1. Otherwise it is 1.
- R5: A host write (`wr_en` high for one cycle) clears `empty` on the next cycle. A byte already in progress still completes with its old value. The written byte is used at the next byte start. If a write and a byte start fall on the same cycle, the byte that starts is the old one.
- R6: If no write occurs between two byte starts, the same byte value is sent again.
- R7: While `stuff_en` is 1, a 0 goes out on the strobe that follows five transmitted 1s in a row. The pending data bit is held back and goes out on the next strobe, so no data bit is lost.
- R8: The count of consecutive 1s carries across byte boundaries. A run that starts in one byte and ends in the next is still broken by an inserted 0.
- R9: While `stuff_en` is 0, exactly eight strobes send one byte and nothing is inserted. For example, 0xFF and 0x7E go out bit for bit.
- R10: Every 0 sent, including an inserted 0, resets the run count, so the next insertion needs five new 1s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte written by the host |
| stuff_en | input | 1 | Enables zero insertion after five 1s |
| irq_en | input | 1 | Interrupt enable for the empty event |
| bit_req | input | 1 | One-cycle strobe marking one outgoing bit position |
| tx_bit | output | 1 | Outgoing serial bit |
| empty | output | 1 | Holding register may be refilled |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a run of 1s that straddles a byte boundary. The run must reach five either exactly at the last data bit of one byte or partway into the next. The inserted 0 then takes a strobe that belongs to neither byte. The bench keeps its own run count across bytes and chooses byte values so the run reaches five at those points. It also changes the holding register in the middle of a byte. For each byte it works out how many strobes to issue, including the extra strobe each inserted 0 takes.

// File: rtl/serial_slot_tx.sv
module serial_slot_tx #(
  parameter int BYTE_W  = 8,
  parameter int RUN_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stuff_en,
  input  logic              irq_en,
  input  logic              bit_req,
  output logic              tx_bit,
  output logic              empty,
  output logic              irq_n
);
  localparam int CW = $clog2(BYTE_W);
  localparam int OW = $clog2(RUN_MAX + 1);

  logic [BYTE_W-1:0] hold_q, sh_q;
  logic [CW-1:0]     cnt_q;
  logic [OW-1:0]     ones_q;

  wire stuff_now = bit_req && stuff_en && (ones_q == OW'(RUN_MAX));
  wire data_now  = bit_req && !stuff_now;
  wire first     = (cnt_q == '0);
  wire last      = (cnt_q == CW'(BYTE_W - 1));
  wire data_bit  = first ? hold_q[0] : sh_q[0];
  wire sent_bit  = stuff_now ? 1'b0 : data_bit;

  assign irq_n = !(empty && irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      ones_q <= '0;
      tx_bit <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (wr_en) hold_q <= wr_data;
      if (bit_req) begin
        tx_bit <= sent_bit;
        if (!sent_bit)                    ones_q <= '0;
        else if (ones_q != OW'(RUN_MAX))  ones_q <= ones_q + 1'b1;
      end
      if (data_now) begin
        sh_q  <= first ? (hold_q >> 1) : (sh_q >> 1);
        cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
      if (wr_en)                empty <= 1'b0;
      else if (data_now && last) empty <= 1'b1;
    end
  end

  logic             req_q, stuff_q;
  logic [OW:0]      run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      stuff_q <= 1'b0;
      run_q   <= '0;
    end else begin
      req_q   <= bit_req;
      stuff_q <= stuff_en;
      if (req_q) run_q <= tx_bit ? ((run_q == (OW+1)'(RUN_MAX + 1)) ? run_q : run_q + 1'b1) : '0;
    end
  end

  // R7
  no_six_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && stuff_q && tx_bit) |-> (run_q < (OW+1)'(RUN_MAX)));

  // R7
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |=> ($stable(sh_q) && $stable(cnt_q) && !tx_bit));

  // R5
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !empty);

  // R3
  empty_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(bit_req));

  // R2
  bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_req |=> $stable(tx_bit));
endmodule

// File: tb/test_serial_slot_tx.sv
module test_serial_slot_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       stuff_en = 1'b0;
  logic       irq_en = 1'b1;
  logic       bit_req = 1'b0;
  logic       tx_bit, empty, irq_n;

  int checks = 0, fails = 0;
  bit    exp_q[$];
  string tag_q[$];
  int    run = 0;
  int    last_n = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  serial_slot_tx i_serial_slot_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stuff_en(stuff_en), .irq_en(irq_en), .bit_req(bit_req),
    .tx_bit(tx_bit), .empty(empty), .irq_n(irq_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_bit(input bit b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
    last_n++;
    run = b ? ((run >= 5) ? 5 : run + 1) : 0;
  endtask

  task automatic push_byte(input logic [7:0] b, input string tag);
    last_n = 0;
    for (int i = 0; i < 8; i++) begin
      if (stuff_en && run == 5) push_bit(1'b0, {tag, "/stuff R7 R10"});
      push_bit(b[i], tag);
    end
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_req = 1'b1;
      @(negedge clk) bit_req = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
    check("R5 empty cleared by write", empty, 0);
  endtask

  always begin
    @(posedge clk);
    if (bit_req && rst_n) begin
      @(negedge clk);
      if (exp_q.size() == 0) check("R2 unexpected bit", 1, 0);
      else check({"R2 bit ", tag_q.pop_front()}, tx_bit, exp_q.pop_front());
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          check("watchdog", 1, 0);
          $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx_bit reset", tx_bit, 0);
    check("R1 empty reset", empty, 1);
    check("R4 irq low when empty and enabled", irq_n, 0);
    irq_en = 1'b0;
    #1 check("R4 irq high when disabled", irq_n, 1);
    irq_en = 1'b1;

    push_byte(8'h00, "R1 reset holding byte");
    strobe(last_n);

    host_write(8'hA5);
    check("R4 irq high after write", irq_n, 1);
    push_byte(8'hA5, "R2 0xA5");
    strobe(7);
    check("R9 not empty after 7 strobes", empty, 0);
    strobe(1);
    check("R3 empty after bit 7", empty, 1);
    check("R4 irq low on empty", irq_n, 0);

    push_byte(8'hA5, "R6 repeat 0xA5");
    strobe(last_n);
    check("R6 empty after repeat", empty, 1);

    host_write(8'hFF);
    push_byte(8'hFF, "R9 0xFF unstuffed");
    strobe(last_n);
    check("R9 eight strobes for 0xFF", last_n, 8);

    stuff_en = 1'b1;
    host_write(8'hFF);
    push_byte(8'hFF, "R7 0xFF stuffed");
    check("R7 extra strobes", last_n, 10);
    strobe(last_n - 1);
    check("R3 not empty before last data bit", empty, 0);
    strobe(1);
    check("R3 empty after stuffed byte", empty, 1);

    host_write(8'h07);
    push_byte(8'h07, "R8 run across boundary");
    strobe(last_n);

    host_write(8'hC0);
    push_byte(8'hC0, "R8 0xC0");
    strobe(4);
    host_write(8'h1F);
    strobe(last_n - 4);
    check("R3 empty after 0xC0", empty, 1);
    push_byte(8'h1F, "R5 mid-byte write 0x1F");
    strobe(last_n);

    push_byte(8'h1F, "R10 repeat 0x1F");
    strobe(last_n);

    stuff_en = 1'b0;
    host_write(8'h7E);
    push_byte(8'h7E, "R9 0x7E unstuffed");
    strobe(last_n);
    check("R9 eight strobes for 0x7E", last_n, 8);

    repeat (3) @(negedge clk);
    check("R2 all expected bits consumed", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule